// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is the configuration register bank of a legacy PC chipset, seen by the processor through two I/O ports. A write to the index port selects one of fourteen configuration bytes. The next access to the data port reads or writes that byte. After every data-port access, valid or not, the index returns to an idle value. Software must therefore write the index again before each data access.

Each configuration byte has its own mask of writable bits. One register also has a bit that a write always sets. The block sends a few decoded controls to the rest of the chipset: a halt-reset enable, an external cache enable, and the four raw shadow-control bytes. It raises a one-cycle recalculate pulse whenever a shadow-related register is written. Two general scratch bytes sit at a separate pair of I/O addresses.

Top module: `cfg_port_bank`

## Requirements
- R1: A write to I/O address 0022h loads the index latch with the write data. Reset sets the index to FFh. A read of 0022h returns FFh.
- R2: Address 0024h is the data port. An access there is valid only when the index is in 20h..2Dh and is not 2Ch. An invalid write changes nothing, and an invalid read returns FFh.
- R3: Every data-port access, valid or not and read or write, sets the index to FFh. A second data access with no new index write in between is therefore invalid.
- R4: A valid write stores the write data ANDed with the register's mask. Masks by index: 20h=3Fh, 24h=F7h, 28h=E3h, 2Ah=FBh, 2Ch=00h, all others FFh. Masked bits read back as 0.
- R5: After any valid write to register 2Ah, bit 2 of that register reads as 1.
- R6: After reset the registers hold 22h=84h, 24h=87h, 25h=F0h, 27h=D1h, 28h=80h, 29h=10h, 2Ah=80h, 2Bh=10h and 2Dh=40h. All other registers hold 00h.
- R7: `halt_reset_en` is the inverse of register 20h bit 1. `ext_cache_en` equals register 21h bit 4. After reset they are 1 and 0.
- R8: Two scratch bytes are plain read/write. Address 00E1h selects byte 1 and 00E2h selects byte 0. Both reset to FFh.
- R9: `shd_bios_ctl`, `shd_seg_en`, `shd_low_ctl` and `shd_ext_ctl` always show registers 22h, 23h, 26h and 2Dh.
- R10: `remap_pulse` is high for exactly the one cycle after each valid write to register 22h, 23h, 26h or 2Dh. This holds even when the written value does not change the register. Writes to any other register never raise it.
- R11: `io_rdata` depends only on the current cycle's inputs and state. It is FFh when `io_rd` is low and when the address is not 0022h, 0024h, 00E1h or 00E2h. All 16 address bits are decoded.
- R12: When `io_rd` and `io_wr` are both high on a mapped port, the read returns the contents from before the write. The write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| halt_reset_en | output | 1 | Halt-reset enable |
| ext_cache_en | output | 1 | External cache enable |
| shd_bios_ctl | output | 8 | Register 22h |
| shd_seg_en | output | 8 | Register 23h |
| shd_low_ctl | output | 8 | Register 26h |
| shd_ext_ctl | output | 8 | Register 2Dh |
| remap_pulse | output | 1 | Shadow-map recalculate pulse |

## Verification
The recalculate pulse for one shadow register falls in the same cycle as the index write for the next one. The bench sets this up by writing 22h and then 23h back to back, with no idle cycle. The index load, the pulse and the second register update must all match the reference model on every clock.

A read and a write to the data port can also fall in the same cycle. That case must return the old contents and then store the masked new value.

// File: rtl/cfgp_pkg.sv
// Package: register layout, write masks, reset values and forced bits of
// the configuration bank. All tables are indexed by offset from the base.
package cfgp_pkg;

    localparam int          NREG     = 14;      // configuration bytes
    localparam int          OFF_W    = 4;       // offset width
    localparam logic [7:0]  REG_BASE = 8'h20;   // first index
    localparam logic [7:0]  REG_HOLE = 8'h2C;   // unreachable index
    localparam logic [7:0]  IDX_IDLE = 8'hFF;   // index after a data access

    // Offsets whose contents drive outputs
    localparam int OFF_HALT  = 0;
    localparam int OFF_CACHE = 1;
    localparam int OFF_BIOS  = 2;
    localparam int OFF_SEG   = 3;
    localparam int OFF_LOW   = 6;
    localparam int OFF_EXT   = 13;

    // Writable bits of each register
    function automatic logic [7:0] wmask(input int off);
        case (off)
            0:       return 8'h3F;
            4:       return 8'hF7;
            8:       return 8'hE3;
            10:      return 8'hFB;
            12:      return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    // Value loaded by reset
    function automatic logic [7:0] rst_val(input int off);
        case (off)
            2:       return 8'h84;
            4:       return 8'h87;
            5:       return 8'hF0;
            7:       return 8'hD1;
            8:       return 8'h80;
            9:       return 8'h10;
            10:      return 8'h80;
            11:      return 8'h10;
            13:      return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that every write sets
    function automatic logic [7:0] force_set(input int off);
        return (off == 10) ? 8'h04 : 8'h00;
    endfunction

    // Registers whose write asks for a shadow-map recalculation
    function automatic logic is_remap(input int off);
        return (off == OFF_BIOS) || (off == OFF_SEG) ||
               (off == OFF_LOW)  || (off == OFF_EXT);
    endfunction

    // Decoded port hits of one bus cycle
    typedef struct packed {
        logic idx_wr;    // write to the index port
        logic data_rd;   // read of the data port
        logic data_wr;   // write to the data port
        logic scr_hit;   // access to either scratch byte
        logic scr_hi;    // scratch byte 1 selected
        logic scr_wr;    // write to a scratch byte
    } port_hit_t;

endpackage

// File: rtl/cfgp_decode.sv
// Address decoder: turns address and strobes into per-port hits.
// Assumes at most one access per cycle per strobe and full address decode.
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0024,
    parameter logic [ADDR_W-1:0] SCR_HI   = 16'h00E1,
    parameter logic [ADDR_W-1:0] SCR_LO   = 16'h00E2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output port_hit_t         hit
);
    // Compare the address against each port
    always_comb begin
        hit.idx_wr  = wr && (addr == IDX_PORT);
        hit.data_rd = rd && (addr == DAT_PORT);
        hit.data_wr = wr && (addr == DAT_PORT);
        hit.scr_hi  = (addr == SCR_HI);
        hit.scr_hit = hit.scr_hi || (addr == SCR_LO);
        hit.scr_wr  = wr && hit.scr_hit;
    end
endmodule

// File: rtl/cfgp_index.sv
// Index latch: loaded by index-port writes, returned to idle by any
// data-port access. Also reports whether the index selects a register.
// Assumes an index write and a data access never share a cycle.
module cfgp_index
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             data_acc,
    input  logic [7:0]       wdata,
    output logic [7:0]       idx,
    output logic             sel_ok,
    output logic [OFF_W-1:0] sel_off
);
    logic [7:0] rel;

    // Hold the index; data accesses park it at the idle value
    always_ff @(posedge clk) begin
        if (!rst_n)        idx <= IDX_IDLE;
        else if (idx_wr)   idx <= wdata;
        else if (data_acc) idx <= IDX_IDLE;
    end

    // Range check against the register window, skipping the hole
    always_comb begin
        rel     = idx - REG_BASE;
        sel_ok  = (rel < 8'(NREG)) && (idx != REG_HOLE);
        sel_off = rel[OFF_W-1:0];
    end

    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && idx_wr) |=> (idx == $past(wdata)));
    a_r3_index_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && data_acc && !idx_wr) |=> (idx == IDX_IDLE));
    a_r2_hole_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == REG_HOLE) |-> !sel_ok);
endmodule

// File: rtl/cfgp_bank.sv
// Register bank: fourteen masked configuration bytes with per-register
// reset values, a forced bit, a read mux and the recalculate pulse.
// Assumes wr_en is already qualified by a valid index.
module cfgp_bank
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte,
    output logic             halt_bit,
    output logic             cache_bit,
    output logic [7:0]       bios_q,
    output logic [7:0]       seg_q,
    output logic [7:0]       low_q,
    output logic [7:0]       ext_q,
    output logic             remap_pulse
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int I = g;
        // One configuration byte: masked store plus forced bits
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[I] <= rst_val(I);
            else if (wr_en && (off == OFF_W'(I)))
                regs[I] <= (wdata & wmask(I)) | force_set(I);
        end

        a_r4_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((regs[I] & ~(wmask(I) | force_set(I))) == 8'h00));
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !(wr_en && (off == OFF_W'(I)))) |=> $stable(regs[I]));
    end

    // Read mux over the selected offset
    always_comb begin
        rd_byte = 8'hFF;
        for (int i = 0; i < NREG; i++)
            if (off == OFF_W'(i)) rd_byte = regs[i];
    end

    // Decoded controls and raw shadow bytes
    always_comb begin
        halt_bit  = ~regs[OFF_HALT][1];
        cache_bit = regs[OFF_CACHE][4];
        bios_q    = regs[OFF_BIOS];
        seg_q     = regs[OFF_SEG];
        low_q     = regs[OFF_LOW];
        ext_q     = regs[OFF_EXT];
    end

    // One-cycle pulse after a write to a shadow-related register
    always_ff @(posedge clk) begin
        if (!rst_n) remap_pulse <= 1'b0;
        else        remap_pulse <= wr_en && is_remap(int'(off));
    end

    a_r5_forced_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && (off == OFF_W'(10))) |=> regs[10][2]);
    a_r10_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && is_remap(int'(off))) |=> remap_pulse);
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |=> !remap_pulse);
endmodule

// File: rtl/cfgp_scratch.sv
// Scratch pair: two plain read/write bytes selected by the decoder.
// Assumes the decoder qualifies the write strobe with the address.
module cfgp_scratch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sel_hi,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte
);
    logic [7:0] byte_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_scr
        // Store one scratch byte
        always_ff @(posedge clk) begin
            if (!rst_n)                       byte_q[g] <= 8'hFF;
            else if (wr && (sel_hi == g[0]))  byte_q[g] <= wdata;
        end
        a_r8_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !(wr && (sel_hi == g[0]))) |=> $stable(byte_q[g]));
    end

    // Select the addressed byte
    always_comb rd_byte = sel_hi ? byte_q[1] : byte_q[0];
endmodule

// File: rtl/cfg_port_bank.sv
// Top: index/data configuration port with scratch bytes. Combines the
// decoder, index latch, register bank and scratch pair, and forms the
// combinational read data. Assumes one bus access per cycle.
module cfg_port_bank
    import cfgp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [7:0]        io_rdata,
    output logic              halt_reset_en,
    output logic              ext_cache_en,
    output logic [7:0]        shd_bios_ctl,
    output logic [7:0]        shd_seg_en,
    output logic [7:0]        shd_low_ctl,
    output logic [7:0]        shd_ext_ctl,
    output logic              remap_pulse
);
    port_hit_t        hit;
    logic [7:0]       idx;
    logic             sel_ok;
    logic [OFF_W-1:0] sel_off;
    logic [7:0]       bank_rd;
    logic [7:0]       scr_rd;
    logic             bank_wr;

    cfgp_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (ADDR_W'(16'h0022)),
        .DAT_PORT (ADDR_W'(16'h0024)),
        .SCR_HI   (ADDR_W'(16'h00E1)),
        .SCR_LO   (ADDR_W'(16'h00E2))
    ) u_dec (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .hit  (hit)
    );

    cfgp_index u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (hit.idx_wr),
        .data_acc (hit.data_rd || hit.data_wr),
        .wdata    (io_wdata),
        .idx      (idx),
        .sel_ok   (sel_ok),
        .sel_off  (sel_off)
    );

    // Only a data write under a valid index reaches the bank
    always_comb bank_wr = hit.data_wr && sel_ok;

    cfgp_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bank_wr),
        .off         (sel_off),
        .wdata       (io_wdata),
        .rd_byte     (bank_rd),
        .halt_bit    (halt_reset_en),
        .cache_bit   (ext_cache_en),
        .bios_q      (shd_bios_ctl),
        .seg_q       (shd_seg_en),
        .low_q       (shd_low_ctl),
        .ext_q       (shd_ext_ctl),
        .remap_pulse (remap_pulse)
    );

    cfgp_scratch u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hit.scr_wr),
        .sel_hi  (hit.scr_hi),
        .wdata   (io_wdata),
        .rd_byte (scr_rd)
    );

    // Read data: valid register, scratch byte, else all ones
    always_comb begin
        if (hit.data_rd && sel_ok)     io_rdata = bank_rd;
        else if (io_rd && hit.scr_hit) io_rdata = scr_rd;
        else                           io_rdata = 8'hFF;
    end

    a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == 8'hFF));
    a_r2_invalid_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.data_rd && !sel_ok) |-> (io_rdata == 8'hFF));
    a_r1_index_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr == ADDR_W'(16'h0022))) |-> (io_rdata == 8'hFF));
    a_r7_idx_untouched_by_scratch: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hit.scr_hit) |=> $stable(idx));
endmodule

// File: tb/cfg_port_bank_test.sv
// Bench: behavioural reference model, compared on every clock.
module cfg_port_bank_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        io_rd, io_wr;
    logic [7:0]  io_rdata, shd_bios_ctl, shd_seg_en, shd_low_ctl, shd_ext_ctl;
    logic        halt_reset_en, ext_cache_en, remap_pulse;

    cfg_port_bank uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    logic [7:0] m_reg [14];
    logic [7:0] m_scr [2];
    logic [7:0] m_idx;
    logic       m_pulse;

    function automatic logic [7:0] b_mask(int o);
        case (o) 0: return 8'h3F; 4: return 8'hF7; 8: return 8'hE3;
                 10: return 8'hFB; 12: return 8'h00; default: return 8'hFF; endcase
    endfunction

    function automatic logic [7:0] b_rst(int o);
        case (o) 2: return 8'h84; 4: return 8'h87; 5: return 8'hF0; 7: return 8'hD1;
                 8: return 8'h80; 10: return 8'h80; 9: return 8'h10; 11: return 8'h10;
                 13: return 8'h40; default: return 8'h00; endcase
    endfunction

    function automatic bit b_valid(logic [7:0] i);
        return (i >= 8'h20) && (i <= 8'h2D) && (i != 8'h2C);
    endfunction

    task automatic m_reset();
        for (int o = 0; o < 14; o++) m_reg[o] = b_rst(o);
        m_scr[0] = 8'hFF; m_scr[1] = 8'hFF; m_idx = 8'hFF; m_pulse = 1'b0;
    endtask

    function automatic logic [7:0] m_rdata(logic [15:0] a, logic rd);
        if (!rd) return 8'hFF;
        if (a == 16'h0024 && b_valid(m_idx)) return m_reg[m_idx - 8'h20];
        if (a == 16'h00E1) return m_scr[1];
        if (a == 16'h00E2) return m_scr[0];
        return 8'hFF;
    endfunction

    task automatic chk(string what, string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare everything, advance the model
    task automatic cyc(logic [15:0] a, logic [7:0] d, logic rd, logic wr, string tag);
        logic nxt_pulse;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_rd = rd; io_wr = wr;
        #1;
        chk("rdata",  tag,   io_rdata, m_rdata(a, rd));
        chk("halt",   "R7",  {7'd0, halt_reset_en}, {7'd0, ~m_reg[0][1]});
        chk("cache",  "R7",  {7'd0, ext_cache_en},  {7'd0, m_reg[1][4]});
        chk("shd22",  "R9",  shd_bios_ctl, m_reg[2]);
        chk("shd23",  "R9",  shd_seg_en,   m_reg[3]);
        chk("shd26",  "R9",  shd_low_ctl,  m_reg[6]);
        chk("shd2D",  "R9",  shd_ext_ctl,  m_reg[13]);
        chk("pulse",  "R10", {7'd0, remap_pulse}, {7'd0, m_pulse});
        nxt_pulse = 1'b0;
        if (wr && a == 16'h0022) m_idx = d;
        if ((rd || wr) && a == 16'h0024) begin
            if (wr && b_valid(m_idx)) begin
                int o;
                o = int'(m_idx - 8'h20);
                m_reg[o] = d & b_mask(o);
                if (o == 10) m_reg[o][2] = 1'b1;
                nxt_pulse = (o == 2) || (o == 3) || (o == 6) || (o == 13);
            end
            m_idx = 8'hFF;
        end
        if (wr && a == 16'h00E1) m_scr[1] = d;
        if (wr && a == 16'h00E2) m_scr[0] = d;
        m_pulse = nxt_pulse;
    endtask

    task automatic wreg(logic [7:0] i, logic [7:0] v, string tag);
        cyc(16'h0022, i, 1'b0, 1'b1, tag);
        cyc(16'h0024, v, 1'b0, 1'b1, tag);
    endtask

    task automatic rreg(logic [7:0] i, string tag);
        cyc(16'h0022, i, 1'b0, 1'b1, tag);
        cyc(16'h0024, 8'h00, 1'b1, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_rd = 1'b0; io_wr = 1'b0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6 reset state, R1 index read, R11 idle read
        cyc(16'h0024, 8'h00, 1'b0, 1'b0, "R11");
        cyc(16'h0022, 8'h00, 1'b1, 1'b0, "R1");
        for (int i = 8'h20; i <= 8'h2D; i++) rreg(8'(i), "R6");

        // R4 masks and R5 forced bit, all-ones then all-zeros
        for (int i = 8'h20; i <= 8'h2D; i++) begin
            wreg(8'(i), 8'hFF, "R4"); rreg(8'(i), "R4");
        end
        for (int i = 8'h20; i <= 8'h2D; i++) begin
            wreg(8'(i), 8'h00, "R5"); rreg(8'(i), "R5");
        end

        // R7 decoded controls
        wreg(8'h20, 8'h02, "R7"); wreg(8'h21, 8'h10, "R7");
        wreg(8'h20, 8'hFD, "R7"); wreg(8'h21, 8'hEF, "R7");

        // R2 invalid indices ignored
        wreg(8'h1F, 8'h55, "R2"); rreg(8'h1F, "R2");
        wreg(8'h2C, 8'h55, "R2"); rreg(8'h2C, "R2");
        wreg(8'h2E, 8'h55, "R2"); wreg(8'h80, 8'h55, "R2");
        rreg(8'h2D, "R2");

        // R3 second data access without new index
        wreg(8'h25, 8'h11, "R3");
        cyc(16'h0024, 8'h22, 1'b0, 1'b1, "R3");
        rreg(8'h25, "R3");
        cyc(16'h0024, 8'h00, 1'b1, 1'b0, "R3");
        cyc(16'h0022, 8'h27, 1'b0, 1'b1, "R3");
        cyc(16'h0024, 8'h00, 1'b1, 1'b0, "R3");
        cyc(16'h0024, 8'h00, 1'b1, 1'b0, "R3");

        // R8 scratch bytes
        cyc(16'h00E1, 8'h00, 1'b1, 1'b0, "R8");
        cyc(16'h00E1, 8'hA5, 1'b0, 1'b1, "R8");
        cyc(16'h00E2, 8'h5A, 1'b0, 1'b1, "R8");
        cyc(16'h00E1, 8'h00, 1'b1, 1'b0, "R8");
        cyc(16'h00E2, 8'h00, 1'b1, 1'b0, "R8");

        // R12 read and write together
        cyc(16'h0022, 8'h27, 1'b0, 1'b1, "R12");
        cyc(16'h0024, 8'h3C, 1'b1, 1'b1, "R12");
        rreg(8'h27, "R12");
        cyc(16'h00E2, 8'h77, 1'b1, 1'b1, "R12");
        cyc(16'h00E2, 8'h00, 1'b1, 1'b0, "R12");

        // R11 unmapped and aliased addresses, low strobe
        cyc(16'h0023, 8'h00, 1'b1, 1'b0, "R11");
        cyc(16'h0124, 8'h00, 1'b1, 1'b0, "R11");
        cyc(16'h0022, 8'h22, 1'b0, 1'b1, "R11");
        cyc(16'h0024, 8'h00, 1'b0, 1'b0, "R11");
        cyc(16'h0024, 8'h00, 1'b1, 1'b0, "R11");

        // R10 and R9: pulse overlapping the next index write, rewrites
        wreg(8'h22, 8'h84, "R10"); wreg(8'h23, 8'h0F, "R10");
        wreg(8'h26, 8'h70, "R10"); wreg(8'h2D, 8'hC3, "R10");
        wreg(8'h2D, 8'hC3, "R10"); wreg(8'h24, 8'h01, "R10");
        cyc(16'h0024, 8'h00, 1'b0, 1'b0, "R10");

        // R6 again after a mid-run reset
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        m_reset();
        for (int i = 8'h20; i <= 8'h2D; i++) rreg(8'(i), "R6");
        cyc(16'h00E1, 8'h00, 1'b1, 1'b0, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule